// File: doc/BRIEF.md
# Sampled von Neumann Debiaser

This block sits between a free-running entropy source and the health tests that follow it. While the source enable is high, it takes one raw bit every programmed number of clock cycles. It then removes bias by looking at the samples in non-overlapping pairs: a pair whose two bits differ produces one output bit, and a pair whose two bits are equal produces nothing. Alongside the balancer, a run monitor watches the raw samples. It raises a one-cycle error when the same value has been collected 32 times in a row.

A bypass control removes both the pair balancer and the run monitor, so that every raw sample appears directly at the output. In bypass the sampling interval has a floor of 17 cycles, so the stage downstream always gets at least that much time per bit. A synchronous soft clear returns the interval counter, the pending half-pair and the run count to their starting state without a full reset.

Top module: `entropy_debias`

## Requirements
- R1: With source enable held high and a programmed interval P (P from 1 to 2^32-1, bypass low), the first raw sample is taken at the P-th rising edge after enable rises, and later samples every P edges. A balancer output from a pair appears on `bit_vld` in the cycle right after the edge that took the pair's second sample.
- R2: When bypass is high and the programmed interval is below 17, the block samples every 17 cycles. An interval of 17 or more is used as programmed.
- R3: When bypass is low, a programmed interval of 0 behaves as 1, so one sample is taken on every clock edge.
- R4: With bypass low, samples are taken as pairs that do not overlap, first sample then second. The pair 0,1 outputs `bit_out`=0, the pair 1,0 outputs `bit_out`=1, and the pairs 0,0 and 1,1 raise no `bit_vld`.
- R5: With bypass low, the 32nd consecutive identical raw sample raises `stuck_err` in the cycle after the edge that took it. The 31st does not.
- R6: A raw sample that differs from the one before it restarts the run count at one.
- R7: After an error the run count starts again from zero, so a source that stays stuck reports once more for every further 32 samples.
- R8: With bypass high, every sample produces `bit_vld` with `bit_out` equal to the sampled raw bit, and `stuck_err` never rises.
- R9: While `src_en` is low, no sample is taken: `bit_vld` and `stuck_err` stay low, and the balancer and run states hold.
- R10: A `soft_clr` cycle restarts the interval count, drops a pending half-pair and zeroes the run count. No output pulse appears in the cycle after it.
- R11: During and right after the asynchronous reset, `bit_vld`, `bit_out` and `stuck_err` are low.
- R12: `stuck_err` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Sampling enable; no samples are taken while low |
| raw_bit | input | 1 | Raw entropy bit from the source |
| interval | input | 32 | Clock cycles between two consecutive samples |
| bypass | input | 1 | High: pass raw samples through, with no balancing and no run check |
| soft_clr | input | 1 | Synchronous clear of the counter, half-pair and run state |
| bit_out | output | 1 | Output bit, meaningful while `bit_vld` is high |
| bit_vld | output | 1 | One-cycle strobe for `bit_out` |
| stuck_err | output | 1 | One-cycle pulse when a run of identical samples is detected |

## Verification
A sample is taken at the edge where the interval count reaches P-1. Every result is registered at that same edge, so `bit_vld` and `stuck_err` are due exactly one cycle after the sampling edge: after edge 2P for the first pair, after edge 32 for a stuck source sampled every cycle, and after edge 17 for the first bypassed sample at a small interval. The bench changes inputs on the falling edge, holds the raw bit for one whole interval per sample, and logs every output pulse on the falling edge together with the count of rising edges so far. The checks then compare the pulse counts, the bit values and the edge counts of the pulses with those expected values.

// File: rtl/debias_pkg.sv
package debias_pkg;

  localparam int unsigned DEF_CNT_W   = 32;
  localparam int unsigned DEF_MIN_BYP = 17;
  localparam int unsigned DEF_RUN_LEN = 32;

  // One candidate output: strobe plus data bit.
  typedef struct packed {
    logic vld;
    logic val;
  } dbit_t;

endpackage

// File: rtl/sample_timer.sv
module sample_timer #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MIN_BYP = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic             soft_clr,
  input  logic             bypass,
  input  logic [CNT_W-1:0] interval,
  output logic             tick
);

  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_BYP);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  // Interval actually applied: bypass floor, and zero read as one.
  function automatic logic [CNT_W-1:0] period_of(input logic [CNT_W-1:0] ivl,
                                                 input logic byp);
    if (byp && (ivl < FLOOR)) return FLOOR;
    if (ivl == '0)            return ONE;
    return ivl;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = period_of(interval, bypass) - ONE;
  assign tick = src_en && !soft_clr && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (soft_clr) cnt <= '0;
    else if (src_en) begin
      if (cnt >= last) cnt <= '0;
      else             cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/pair_balancer.sv
module pair_balancer (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic smp,
  output logic emit,
  output logic ebit
);

  logic half_vld;
  logic half_val;

  // A completed pair with unequal bits yields its first bit.
  function automatic logic pair_differs(input logic first, input logic second);
    return first ^ second;
  endfunction

  assign emit = tick && !clr && half_vld && pair_differs(half_val, smp);
  assign ebit = half_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_vld <= 1'b0;
      half_val <= 1'b0;
    end else if (clr) begin
      half_vld <= 1'b0;
      half_val <= 1'b0;
    end else if (tick) begin
      half_vld <= !half_vld;
      if (!half_vld) half_val <= smp;
    end
  end

endmodule

// File: rtl/run_monitor.sv
module run_monitor #(
  parameter int unsigned RUN_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic smp,
  output logic hit
);

  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] TOP = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_cnt;
  logic             run_val;
  logic             same;

  // Sample extends the current run only if a run exists and values match.
  function automatic logic extends_run(input logic [RUN_W-1:0] c,
                                       input logic v, input logic b);
    return (c != '0) && (v == b);
  endfunction

  assign same = extends_run(run_cnt, run_val, smp);
  assign hit  = tick && !clr && same && (run_cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_val <= 1'b0;
    end else if (clr) begin
      run_cnt <= '0;
      run_val <= 1'b0;
    end else if (tick) begin
      if (hit) begin
        run_cnt <= '0;
      end else if (!same) begin
        run_val <= smp;
        run_cnt <= RUN_W'(1);
      end else begin
        run_cnt <= run_cnt + RUN_W'(1);
      end
    end
  end

endmodule

// File: rtl/entropy_debias.sv
module entropy_debias
  import debias_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned MIN_BYP = DEF_MIN_BYP,
  parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic             raw_bit,
  input  logic [CNT_W-1:0] interval,
  input  logic             bypass,
  input  logic             soft_clr,
  output logic             bit_out,
  output logic             bit_vld,
  output logic             stuck_err
);

  // Named internal events, visible to the bound checker.
  logic  sample_tick;
  logic  pair_emit;
  logic  pair_bit;
  logic  run_hit;
  logic  stage_clr;
  dbit_t nxt;

  assign stage_clr = soft_clr | bypass;

  sample_timer #(.CNT_W(CNT_W), .MIN_BYP(MIN_BYP)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en   (src_en),
    .soft_clr (soft_clr),
    .bypass   (bypass),
    .interval (interval),
    .tick     (sample_tick)
  );

  pair_balancer u_bal (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stage_clr),
    .tick  (sample_tick),
    .smp   (raw_bit),
    .emit  (pair_emit),
    .ebit  (pair_bit)
  );

  run_monitor #(.RUN_LEN(RUN_LEN)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stage_clr),
    .tick  (sample_tick),
    .smp   (raw_bit),
    .hit   (run_hit)
  );

  always_comb begin
    if (bypass) begin
      nxt.vld = sample_tick;
      nxt.val = sample_tick & raw_bit;
    end else begin
      nxt.vld = pair_emit;
      nxt.val = pair_emit & pair_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_vld   <= 1'b0;
      bit_out   <= 1'b0;
      stuck_err <= 1'b0;
    end else begin
      bit_vld   <= nxt.vld;
      bit_out   <= nxt.val;
      stuck_err <= run_hit;
    end
  end

endmodule

// File: rtl/debias_checker.sv
module debias_checker #(
  parameter int unsigned MIN_BYP = 17
) (
  input logic clk,
  input logic rst_n,
  input logic src_en,
  input logic bypass,
  input logic soft_clr,
  input logic sample_tick,
  input logic bit_vld,
  input logic stuck_err
);

  // Enabled cycles since the last sample or clear, saturating.
  logic [7:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap <= '0;
    else if (soft_clr || sample_tick) gap <= '0;
    else if (src_en && gap != 8'hFF)  gap <= gap + 8'd1;
  end

  AST_VALID_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(sample_tick)); // R1

  AST_BYPASS_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && bypass) |-> (32'(gap) >= MIN_BYP - 1)); // R2

  AST_BYPASS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !stuck_err); // R8

  AST_IDLE_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> (!bit_vld && !stuck_err)); // R9

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!bit_vld && !stuck_err)); // R10

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_err |=> !stuck_err); // R12

endmodule

bind entropy_debias debias_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_en      (src_en),
  .bypass      (bypass),
  .soft_clr    (soft_clr),
  .sample_tick (sample_tick),
  .bit_vld     (bit_vld),
  .stuck_err   (stuck_err)
);

// File: tb/sim_entropy_debias.sv
module sim_entropy_debias;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_en = 1'b0;
  logic        raw_bit = 1'b0;
  logic [31:0] interval = 32'h0000FFFF;
  logic        bypass = 1'b0;
  logic        soft_clr = 1'b0;
  logic        bit_out, bit_vld, stuck_err;

  int nchecks = 0;
  int nerrs = 0;
  int cyc = 0;
  int c0 = 0;
  bit done = 1'b0;

  logic vbits[$];
  int   vstamps[$];
  int   estamps[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  entropy_debias u0 (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .raw_bit(raw_bit),
    .interval(interval), .bypass(bypass), .soft_clr(soft_clr),
    .bit_out(bit_out), .bit_vld(bit_vld), .stuck_err(stuck_err)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WATCHDOG && !done) begin
      done = 1'b1;
      nchecks++;
      nerrs++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  // Output logger, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_vld)   begin vbits.push_back(bit_out); vstamps.push_back(cyc); end
      if (stuck_err) estamps.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start_scn(input logic [31:0] p, input logic byp);
    @(negedge clk);
    src_en = 1'b0;
    bypass = byp;
    interval = p;
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    vbits.delete(); vstamps.delete(); estamps.delete();
  endtask

  // Sample k (lsb first) is held across the k-th window of w edges.
  task automatic run_samples(input logic [63:0] pat, input int n, input int w);
    raw_bit = pat[0];
    src_en = 1'b1;
    c0 = cyc;
    for (int k = 0; k < n; k++) begin
      repeat (w) @(negedge clk);
      raw_bit = (k + 1 < 64) ? pat[k+1] : 1'b0;
    end
    src_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(bit_vld == 1'b0, "R11", "bit_vld after reset", int'(bit_vld), 0);
    chk(stuck_err == 1'b0, "R11", "stuck_err after reset", int'(stuck_err), 0);
    chk(bit_out == 1'b0, "R11", "bit_out after reset", int'(bit_out), 0);
  endtask

  task automatic t_pairs();
    // pairs 01,10,00,11,10 -> outputs 0,1,1
    start_scn(32'd4, 1'b0);
    run_samples(64'h1C6, 10, 4);
    chk(vbits.size() == 3, "R4", "pair output count", vbits.size(), 3);
    if (vbits.size() == 3) begin
      chk(vbits[0] == 1'b0, "R4", "pair 01 value", int'(vbits[0]), 0);
      chk(vbits[1] == 1'b1, "R4", "pair 10 value", int'(vbits[1]), 1);
      chk(vbits[2] == 1'b1, "R4", "last pair 10 value", int'(vbits[2]), 1);
    end
  endtask

  task automatic t_timing();
    start_scn(32'd6, 1'b0);
    run_samples(64'h2, 2, 6);
    chk(vstamps.size() == 1, "R1", "output count", vstamps.size(), 1);
    if (vstamps.size() == 1)
      chk(vstamps[0] - c0 == 12, "R1", "edges to first output", vstamps[0] - c0, 12);
  endtask

  task automatic t_zero_interval();
    start_scn(32'd0, 1'b0);
    run_samples(64'hAAAA, 16, 1);
    chk(vbits.size() == 8, "R3", "outputs at interval 0", vbits.size(), 8);
    if (vstamps.size() >= 2) begin
      chk(vstamps[0] - c0 == 2, "R3", "first output edge", vstamps[0] - c0, 2);
      chk(vstamps[1] - vstamps[0] == 2, "R3", "output spacing", vstamps[1] - vstamps[0], 2);
    end
  endtask

  task automatic t_disabled();
    start_scn(32'd1, 1'b0);
    for (int i = 0; i < 100; i++) begin
      raw_bit = i[0];
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(vbits.size() == 0, "R9", "outputs while disabled", vbits.size(), 0);
    chk(estamps.size() == 0, "R9", "errors while disabled", estamps.size(), 0);
  endtask

  task automatic t_stuck();
    start_scn(32'd1, 1'b0);
    run_samples({33'd0, {31{1'b1}}}, 31, 1);
    chk(estamps.size() == 0, "R5", "errors after 31 ones", estamps.size(), 0);
    start_scn(32'd1, 1'b0);
    run_samples({32'd0, {32{1'b1}}}, 32, 1);
    chk(estamps.size() == 1, "R5", "errors after 32 ones", estamps.size(), 1);
    if (estamps.size() == 1)
      chk(estamps[0] - c0 == 32, "R5", "error edge", estamps[0] - c0, 32);
    start_scn(32'd1, 1'b0);
    run_samples({64{1'b1}}, 64, 1);
    chk(estamps.size() == 2, "R7", "errors after 64 ones", estamps.size(), 2);
    chk(estamps.size() == 2, "R12", "single-cycle pulses in 64 ones", estamps.size(), 2);
    if (estamps.size() == 2)
      chk(estamps[1] - estamps[0] == 32, "R7", "gap between errors", estamps[1] - estamps[0], 32);
  endtask

  task automatic t_restart();
    // 31 ones, a zero, 31 ones
    start_scn(32'd1, 1'b0);
    run_samples({1'b0, {31{1'b1}}, 1'b0, {31{1'b1}}}, 63, 1);
    chk(estamps.size() == 0, "R6", "errors with broken run", estamps.size(), 0);
  endtask

  task automatic t_bypass();
    logic [5:0] p6 = 6'b011001;
    start_scn(32'd17, 1'b1);
    run_samples({58'd0, p6}, 6, 17);
    chk(vbits.size() == 6, "R8", "bypass output count", vbits.size(), 6);
    for (int k = 0; k < 6 && k < vbits.size(); k++)
      chk(vbits[k] == p6[k], "R8", "bypass bit value", int'(vbits[k]), int'(p6[k]));
    start_scn(32'd17, 1'b1);
    run_samples({64{1'b1}}, 40, 17);
    chk(vbits.size() == 40, "R8", "bypass outputs of 40 ones", vbits.size(), 40);
    chk(estamps.size() == 0, "R8", "bypass errors on 40 ones", estamps.size(), 0);
  endtask

  task automatic t_bypass_floor();
    start_scn(32'd3, 1'b1);
    run_samples(64'h2, 3, 17);
    chk(vbits.size() == 3, "R2", "floored output count", vbits.size(), 3);
    if (vstamps.size() == 3) begin
      chk(vstamps[0] - c0 == 17, "R2", "first floored edge", vstamps[0] - c0, 17);
      chk(vstamps[1] - vstamps[0] == 17, "R2", "floored spacing", vstamps[1] - vstamps[0], 17);
      chk(vbits[1] == 1'b1, "R2", "floored bit value", int'(vbits[1]), 1);
    end
  endtask

  task automatic t_clear();
    // Half-pair 0 pending, then cleared; pair 1,0 must give 1.
    start_scn(32'd2, 1'b0);
    run_samples(64'h0, 1, 2);
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    run_samples(64'h1, 2, 2);
    chk(vbits.size() == 1, "R10", "outputs after clearing half-pair", vbits.size(), 1);
    if (vbits.size() == 1)
      chk(vbits[0] == 1'b1, "R10", "value after clear", int'(vbits[0]), 1);
    // Run count cleared between two runs of 31 ones.
    start_scn(32'd1, 1'b0);
    run_samples({64{1'b1}}, 31, 1);
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    run_samples({64{1'b1}}, 31, 1);
    chk(estamps.size() == 0, "R10", "errors after cleared run", estamps.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pairs();
    t_timing();
    t_zero_interval();
    t_disabled();
    t_stuck();
    t_restart();
    t_bypass();
    t_bypass_floor();
    t_clear();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule